// File: doc/BRIEF.md
# Fail-First Vector Element Sequencer

This block walks the elements of a short vector, one element per clock. For each element it subtracts a shared scalar operand from the element value, which it reads through a register-file read port. It produces a condition field classifying the result as negative, positive or zero, and writes that field out on a dedicated port. A selectable data test runs on every result. The first element whose result meets the test ends the loop early, and the vector length is cut back to reflect how far the loop got.

A mode input decides where the failing element falls. In exclusive mode the test is applied before write-back: the failing result is not stored and the new length counts only the passing elements. In inclusive mode the failing result is stored first and is counted in the new length. In both modes the failing element's condition field is still written. Destination registers past the truncation point keep their old contents.

Software-visible sequencing is a start pulse and a one-cycle done pulse. On done, the new length is valid on its output and the element step counter has returned to zero.

Top module: `failFirstSeq`

## Requirements
- R1: Each processed element emits a 4-bit condition field with this encoding: bit 3 is set for a negative result, bit 2 for a positive result, bit 1 for a zero result, and bit 0 is always 0. The sign is taken from the top bit of the DATA_W-bit two's-complement difference.
- R2: Elements are processed in ascending order from index 0, one per clock. The element at index i is read from register srcBase+i. Its result, element minus scalar (wrapping at DATA_W bits), is written to register dstBase+i. The condition field is written with index i. Register addresses wrap modulo 2^ADDR_W.
- R3: With inclMode=0, the failing element's result is not written, and newVl equals the number of elements before it.
- R4: With inclMode=1, the failing element's result is written, and newVl equals its index plus one.
- R5: testSel=0 fails an element whose result is zero. testSel=1 fails an element whose signed result is less than or equal to zero.
- R6: The condition field of the failing element is written in both modes.
- R7: While idle, including the cycle that done is high, stepIdx is 0 and busy is 0.
- R8: When no element fails, every element in the configured length is written and newVl equals vlCfg.
- R9: Destination registers at or beyond the truncation point keep their previous contents.
- R10: done is high for exactly one cycle, and newVl is valid in that cycle. A start with vlCfg=0 gives done one cycle later, with newVl=0 and no writes.
- R11: A start pulse while busy is ignored. It changes neither the running sequence nor its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; accepted only when idle |
| vlCfg | input | VL_W | Configured vector length, 0..VL_MAX |
| inclMode | input | 1 | 1: failing element is written and counted |
| testSel | input | 1 | 0: stop on zero; 1: stop on less-or-equal zero |
| scalarVal | input | DATA_W | Scalar operand subtracted from each element |
| srcBase | input | ADDR_W | First source register |
| dstBase | input | ADDR_W | First destination register |
| rdAddr | output | ADDR_W | Register read address |
| rdData | input | DATA_W | Register read data (same-cycle) |
| wrEn | output | 1 | Register write enable |
| wrAddr | output | ADDR_W | Register write address |
| wrData | output | DATA_W | Register write data |
| crEn | output | 1 | Condition-field write enable |
| crIdx | output | IDX_W | Element index of the condition field |
| crVal | output | 4 | Condition field (bit3 neg, bit2 pos, bit1 zero) |
| busy | output | 1 | A run is in progress |
| stepIdx | output | VL_W | Current element step |
| done | output | 1 | One-cycle end-of-run pulse |
| newVl | output | VL_W | Vector length after truncation |

## Verification
The hardest cases to reach from the ports sit at the two edges of the loop. One is a failure on element 0, which gives a length of 0 in exclusive mode and 1 in inclusive mode. The other is a failure on the final element in inclusive mode, which must give the same length as a run with no failure at all. The bench reaches these by building element vectors whose differences cross zero at exactly the chosen index, with the scalar picked to produce negative, zero and positive results. It also repeats the runs in place, with source and destination equal, so the untouched tail of the register file is visible. A start pulse is also injected while a run is in progress, to show it is ignored.

// File: rtl/failFirstPkg.sv
package failFirstPkg;

  typedef struct packed {
    logic capture;   // latch run configuration
    logic active;    // an element is being processed this cycle
    logic commitWr;  // result of this element goes to the register file
  } seqStrobe_t;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seqState_t;

  localparam int COND_NEG  = 3;
  localparam int COND_POS  = 2;
  localparam int COND_ZERO = 1;

endpackage

// File: rtl/ffDatapath.sv
module ffDatapath
  import failFirstPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int VL_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [VL_W-1:0]   step,
  input  logic              testSel,
  input  logic [DATA_W-1:0] scalarVal,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] dstBase,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              crEn,
  output logic [3:0]        crVal,
  output logic              elemFail
);

  logic [DATA_W-1:0] scalarQ;
  logic [ADDR_W-1:0] srcBaseQ;
  logic [ADDR_W-1:0] dstBaseQ;
  logic              testSelQ;

  logic [DATA_W-1:0] diff;
  logic              isNeg;
  logic              isZero;
  logic              isPos;
  logic [ADDR_W-1:0] stepAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scalarQ  <= '0;
      srcBaseQ <= '0;
      dstBaseQ <= '0;
      testSelQ <= 1'b0;
    end else if (strb.capture) begin
      scalarQ  <= scalarVal;
      srcBaseQ <= srcBase;
      dstBaseQ <= dstBase;
      testSelQ <= testSel;
    end
  end

  // Step index reduced to address width (wraps around the register file)
  generate
    if (ADDR_W >= VL_W) begin : g_stepWide
      assign stepAddr = ADDR_W'(step);
    end else begin : g_stepNarrow
      assign stepAddr = step[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    rdAddr = srcBaseQ + stepAddr;
    wrAddr = dstBaseQ + stepAddr;
    diff   = rdData - scalarQ;
    isNeg  = diff[DATA_W-1];
    isZero = (diff == '0);
    isPos  = !isNeg && !isZero;

    crVal            = '0;
    crVal[COND_NEG]  = isNeg;
    crVal[COND_POS]  = isPos;
    crVal[COND_ZERO] = isZero;

    elemFail = strb.active && (testSelQ ? (isNeg || isZero) : isZero);
    wrData   = diff;
    wrEn     = strb.commitWr;
    crEn     = strb.active;
  end

endmodule

// File: rtl/ffControl.sv
module ffControl
  import failFirstPkg::*;
#(
  parameter int VL_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [VL_W-1:0] vlCfg,
  input  logic            inclMode,
  input  logic            elemFail,
  output seqStrobe_t      strb,
  output logic [VL_W-1:0] step,
  output logic            busy,
  output logic            done,
  output logic [VL_W-1:0] newVl
);

  seqState_t       stateQ;
  logic [VL_W-1:0] stepQ;
  logic [VL_W-1:0] vlQ;
  logic            inclQ;
  logic [VL_W-1:0] newVlQ;
  logic            doneQ;
  logic            lastElem;

  assign lastElem = (stepQ == vlQ - 1'b1);

  always_comb begin
    strb.capture  = (stateQ == SEQ_IDLE) && start;
    strb.active   = (stateQ == SEQ_RUN);
    strb.commitWr = strb.active && (!elemFail || inclQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= SEQ_IDLE;
      stepQ  <= '0;
      vlQ    <= '0;
      inclQ  <= 1'b0;
      newVlQ <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (stateQ)
        SEQ_IDLE: begin
          if (start) begin
            inclQ <= inclMode;
            vlQ   <= vlCfg;
            stepQ <= '0;
            if (vlCfg == '0) begin
              newVlQ <= '0;
              doneQ  <= 1'b1;
            end else begin
              stateQ <= SEQ_RUN;
            end
          end
        end
        SEQ_RUN: begin
          if (elemFail || lastElem) begin
            if (elemFail) begin
              newVlQ <= inclQ ? (stepQ + 1'b1) : stepQ;
            end else begin
              newVlQ <= vlQ;
            end
            stateQ <= SEQ_IDLE;
            stepQ  <= '0;
            doneQ  <= 1'b1;
          end else begin
            stepQ <= stepQ + 1'b1;
          end
        end
        default: stateQ <= SEQ_IDLE;
      endcase
    end
  end

  assign step  = stepQ;
  assign busy  = (stateQ == SEQ_RUN);
  assign done  = doneQ;
  assign newVl = newVlQ;

endmodule

// File: rtl/failFirstSeq.sv
module failFirstSeq
  import failFirstPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int VL_MAX = 8,
  localparam int VL_W  = $clog2(VL_MAX + 1),
  localparam int IDX_W = (VL_MAX > 1) ? $clog2(VL_MAX) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [VL_W-1:0]   vlCfg,
  input  logic              inclMode,
  input  logic              testSel,
  input  logic [DATA_W-1:0] scalarVal,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] dstBase,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              crEn,
  output logic [IDX_W-1:0]  crIdx,
  output logic [3:0]        crVal,
  output logic              busy,
  output logic [VL_W-1:0]   stepIdx,
  output logic              done,
  output logic [VL_W-1:0]   newVl
);

  seqStrobe_t      strb;
  logic            elemFail;
  logic [VL_W-1:0] step;

  ffControl #(.VL_W(VL_W)) ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .vlCfg    (vlCfg),
    .inclMode (inclMode),
    .elemFail (elemFail),
    .strb     (strb),
    .step     (step),
    .busy     (busy),
    .done     (done),
    .newVl    (newVl)
  );

  ffDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VL_W(VL_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .step      (step),
    .testSel   (testSel),
    .scalarVal (scalarVal),
    .srcBase   (srcBase),
    .dstBase   (dstBase),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .crEn      (crEn),
    .crVal     (crVal),
    .elemFail  (elemFail)
  );

  assign stepIdx = step;
  assign crIdx   = step[IDX_W-1:0];

endmodule

// File: rtl/ffSeqChecker.sv
module ffSeqChecker #(
  parameter int VL_MAX = 8,
  parameter int VL_W   = 4,
  parameter int IDX_W  = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             crEn,
  input logic [IDX_W-1:0] crIdx,
  input logic [3:0]       crVal,
  input logic             busy,
  input logic [VL_W-1:0]  stepIdx,
  input logic             done,
  input logic [VL_W-1:0]  newVl
);

  p_cond_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    crEn |-> ($countones(crVal[3:1]) == 1 && !crVal[0]));

  p_ascending_r2: assert property (@(posedge clk) disable iff (!rstN)
    (crEn && $past(crEn)) |-> (crIdx == IDX_W'($past(crIdx) + 1'b1)));

  p_excl_stop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (crEn && !wrEn) |=> !busy);

  p_cond_with_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> crEn);

  p_step_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (stepIdx == '0));

  p_newvl_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (int'(newVl) <= VL_MAX));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind failFirstSeq ffSeqChecker #(.VL_MAX(VL_MAX), .VL_W(VL_W), .IDX_W(IDX_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .crEn    (crEn),
  .crIdx   (crIdx),
  .crVal   (crVal),
  .busy    (busy),
  .stepIdx (stepIdx),
  .done    (done),
  .newVl   (newVl)
);

// File: tb/failFirstSeq_tb_top.sv
`timescale 1ns/1ps
module failFirstSeq_tb_top;

  localparam int DW = 16;
  localparam int AW = 5;
  localparam int VLM = 8;
  localparam int VW = $clog2(VLM + 1);
  localparam int IW = $clog2(VLM);
  localparam int NREG = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [VW-1:0] vlCfg = '0;
  logic inclMode = 1'b0;
  logic testSel = 1'b0;
  logic [DW-1:0] scalarVal = '0;
  logic [AW-1:0] srcBase = '0;
  logic [AW-1:0] dstBase = '0;
  logic [AW-1:0] rdAddr;
  logic [DW-1:0] rdData;
  logic wrEn;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;
  logic crEn;
  logic [IW-1:0] crIdx;
  logic [3:0] crVal;
  logic busy;
  logic [VW-1:0] stepIdx;
  logic done;
  logic [VW-1:0] newVl;

  logic [DW-1:0] rf [NREG];
  int checkCnt = 0;
  int failCnt = 0;
  int cycleCnt = 0;

  always #2 clk = ~clk;

  failFirstSeq #(.DATA_W(DW), .ADDR_W(AW), .VL_MAX(VLM)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .vlCfg(vlCfg), .inclMode(inclMode),
    .testSel(testSel), .scalarVal(scalarVal), .srcBase(srcBase), .dstBase(dstBase),
    .rdAddr(rdAddr), .rdData(rdData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .crEn(crEn), .crIdx(crIdx), .crVal(crVal), .busy(busy), .stepIdx(stepIdx),
    .done(done), .newVl(newVl)
  );

  assign rdData = rf[rdAddr];

  always @(posedge clk) begin
    if (wrEn) rf[wrAddr] <= wrData;
  end

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (cycleCnt > 150000) begin
      failCnt = failCnt + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycleCnt);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checkCnt = checkCnt + 1;
    if (act != exp) begin
      failCnt = failCnt + 1;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: queues of expected per-cycle port activity
  task automatic runCase(input int vals[], input int sc, input int vl, input bit tsel,
                         input bit incl, input int sb, input int db, input bit poke);
    int eCr[$];
    int eWr[$];
    int eWd[$];
    int expVl;
    logic [DW-1:0] mdl [NREG];
    for (int r = 0; r < NREG; r++) rf[r] = DW'(16'hA500 + r);
    for (int i = 0; i < vals.size(); i++) rf[(sb + i) % NREG] = DW'(vals[i]);
    for (int r = 0; r < NREG; r++) mdl[r] = rf[r];

    expVl = vl;
    for (int i = 0; i < vl; i++) begin
      logic [DW-1:0] res;
      bit neg, zer, fl;
      int cf;
      res = DW'(mdl[(sb + i) % NREG] - DW'(sc));
      neg = res[DW-1];
      zer = (res == 0);
      cf = (neg ? 8 : 0) + ((!neg && !zer) ? 4 : 0) + (zer ? 2 : 0);
      fl = tsel ? (neg || zer) : zer;
      eCr.push_back(cf);
      if (!fl || incl) begin
        eWr.push_back(1);
        eWd.push_back(int'(res));
        mdl[(db + i) % NREG] = res;
      end else begin
        eWr.push_back(0);
        eWd.push_back(0);
      end
      if (fl) begin
        expVl = incl ? i + 1 : i;
        break;
      end
    end

    vlCfg = VW'(vl); testSel = tsel; inclMode = incl;
    scalarVal = DW'(sc); srcBase = AW'(sb); dstBase = AW'(db);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < eCr.size(); k++) begin
      chk("R2 busy during run", busy, 1);
      chk("R2 crEn", crEn, 1);
      chk("R2 crIdx ascending", crIdx, k);
      chk("R1 condition field", crVal, eCr[k]);
      chk("R3/R4 wrEn (R6 cond still written)", wrEn, eWr[k]);
      if (eWr[k] == 1) begin
        chk("R2 wrAddr", wrAddr, (db + k) % NREG);
        chk("R2 wrData", wrData, eWd[k]);
      end
      chk("R10 no done mid-run", done, 0);
      if (poke && k == 0 && eCr.size() >= 2) begin
        start = 1'b1; vlCfg = VW'(1); inclMode = ~incl; testSel = ~tsel;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R10 done pulse", done, 1);
    chk("R3/R4/R8 newVl", newVl, expVl);
    chk("R7 busy low at end", busy, 0);
    chk("R7 stepIdx back to 0", stepIdx, 0);
    chk("R10 crEn quiet at end", crEn, 0);
    @(negedge clk);
    chk("R10 done single cycle", done, 0);
    chk("R7 stepIdx idle", stepIdx, 0);
    for (int r = 0; r < NREG; r++) chk("R9 register file contents", rf[r], mdl[r]);
  endtask

  initial begin
    for (int r = 0; r < NREG; r++) rf[r] = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset busy", busy, 0);
    chk("R7 reset stepIdx", stepIdx, 0);
    chk("R10 reset done", done, 0);
    chk("R2 reset wrEn", wrEn, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R5 zero test, in place: 9,8,3,4 minus 3 -> length 2 (R3) / 3 (R4)
    runCase('{9, 8, 3, 4}, 3, 4, 1'b0, 1'b0, 0, 0, 1'b0);
    runCase('{9, 8, 3, 4}, 3, 4, 1'b0, 1'b1, 0, 0, 1'b0);
    // R5 less-or-equal test on same data, separate destination
    runCase('{9, 8, 3, 4}, 3, 4, 1'b1, 1'b0, 0, 16, 1'b0);
    // R5 negative result stops le test but not zero test
    runCase('{5, 1, 7, 9}, 3, 4, 1'b1, 1'b1, 4, 20, 1'b0);
    runCase('{5, 1, 7, 9}, 3, 4, 1'b0, 1'b0, 4, 20, 1'b0);
    // R8 no failure, full length, wrapping source addresses
    runCase('{10, 20, 30, 40, 50, 60, 70, 80}, 2, 8, 1'b1, 1'b0, 28, 8, 1'b0);
    // R3/R4 failure on element 0
    runCase('{3, 9, 9}, 3, 3, 1'b0, 1'b0, 2, 12, 1'b0);
    runCase('{3, 9, 9}, 3, 3, 1'b0, 1'b1, 2, 12, 1'b0);
    // R4 failure on last element in inclusive mode -> newVl == vlCfg
    runCase('{6, 7, 8, 2, 1}, 2, 4, 1'b1, 1'b1, 0, 0, 1'b0);
    // R10 zero length
    runCase('{1, 2}, 0, 0, 1'b0, 1'b0, 0, 8, 1'b0);
    // R11 start while busy is ignored
    runCase('{9, 8, 7, 3, 5, 6}, 3, 6, 1'b0, 1'b0, 8, 24, 1'b1);
    runCase('{9, 8, 7, 6, 5, 4}, 1, 6, 1'b1, 1'b1, 8, 8, 1'b1);
    // R1 large negative wrap and signed le test
    runCase('{16'h7FFF, 16'h8000, 4}, 16'h0001, 3, 1'b1, 1'b0, 10, 30, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule